// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a true dual-port memory with two independent access ports, called left and right. Each port has an active-low select, a read/write control, an active-low output enable, an address and separate input and output data buses. Both ports can reach every word in the same cycle. The model is synchronous to a single clock. Writes take effect at the clock edge. Read data is registered and appears in the cycle after the read is requested. A drive-enable output stands in for the tri-state pad of each port.

The two highest addresses are ordinary storage words that also serve as mailboxes between the ports. When one port writes the top word, an active-low interrupt is raised toward the other port. That interrupt is dropped when the other port reads the same word. The left port signals the right through the top word, and the right port signals the left through the word just below it.

When both ports are selected at the same address, a busy output goes low toward exactly one port. It goes to the port that arrived later, and the right port if both arrived in the same cycle. A write from the busy port is discarded without notice. The ports carry no valid/ready handshake: every selected cycle is accepted, and the busy flag is the only form of back-pressure. Writes dropped while busy are not retried.

Top module: `dpram_mailbox`

## Requirements
- R1: A write on either port (select low, rw low, busy high) stores the input data at the clock edge. A read (select low, rw high) returns the stored word on the data output in the following cycle.
- R2: While select is high, a port writes nothing, does not change the mailbox flags, and its drive-enable is low in the following cycle.
- R3: Drive-enable is high exactly when the previous cycle was a read on that port and the current output enable is low. While drive-enable is low the data output is zero.
- R4: When both ports are selected at one address and only one port's select or address changed since the last cycle, busy goes low toward the port that changed, in that same cycle.
- R5: When both ports' select or address changed in the same cycle and they now match, busy goes low toward the right port only.
- R6: The two busy outputs are never low together. Busy is low only while both ports are selected at equal addresses. While neither port changes, busy stays on the same side.
- R7: A write from a port whose busy is low leaves memory unchanged.
- R8: A left write to the top address (all ones) drives the right interrupt low from the next cycle. A right read of that address releases it.
- R9: A right write to the top address minus one drives the left interrupt low from the next cycle. A left read of that address releases it.
- R10: If a flag's set and clear happen in the same cycle, the flag ends up set.
- R11: A read on one port in the same cycle as a non-busy write by the other port to the same address returns the newly written data.
- R12: During and immediately after reset, both busy and interrupt outputs are high and both drive-enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| l_ce_n | input | 1 | Left select, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data |
| l_drive | output | 1 | Left data output enable |
| l_busy_n | output | 1 | Left busy, active low |
| l_int_n | output | 1 | Left interrupt, active low |
| r_ce_n | input | 1 | Right select, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data |
| r_drive | output | 1 | Right data output enable |
| r_busy_n | output | 1 | Right busy, active low |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds the block with ADDR_W = 6 and DATA_W = 8. With 64 words it can fill and read back the whole array, and the two mailbox words sit next to ordinary words. A random phase confined to four addresses, including both mailboxes, makes contention, busy-blocked writes, same-cycle set and clear of a flag, and write-first reads happen constantly. It compares busy before each edge and compares interrupt and read outputs after each edge.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic [1:0] {
    SIDE_NONE  = 2'd0,
    SIDE_LEFT  = 2'd1,
    SIDE_RIGHT = 2'd2
  } side_e;
endpackage

// File: rtl/dpm_arbiter.sv
module dpm_arbiter
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_sel,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              busy_l,
  output logic              busy_r
);
  logic              l_sel_q, r_sel_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  side_e             loser_q, loser_d;
  logic              match, l_new, r_new;

  assign match = l_sel && r_sel && (l_addr == r_addr);
  assign l_new = (l_sel != l_sel_q) || (l_addr != l_addr_q);
  assign r_new = (r_sel != r_sel_q) || (r_addr != r_addr_q);

  always_comb begin
    if (!match)              loser_d = SIDE_NONE;
    else if (l_new && !r_new) loser_d = SIDE_LEFT;
    else if (r_new)           loser_d = SIDE_RIGHT;  // later right, or tie
    else                      loser_d = loser_q;
  end

  assign busy_l = (loser_d == SIDE_LEFT);
  assign busy_r = (loser_d == SIDE_RIGHT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_sel_q  <= 1'b0;
      r_sel_q  <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      loser_q  <= SIDE_NONE;
    end else begin
      l_sel_q  <= l_sel;
      r_sel_q  <= r_sel;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      loser_q  <= loser_d;
    end
  end

  // R6
  one_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_l && busy_r));
  // R6
  busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_l || busy_r) |-> (l_sel && r_sel && l_addr == r_addr));
  // R5
  tie_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && l_new && r_new) |-> busy_r);
  // R6
  hold_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_l && match) |=> ((l_sel && r_sel && $stable(l_addr) && $stable(r_addr)) |-> busy_l));
endmodule

// File: rtl/dpm_store.sv
module dpm_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_we,
  input  logic              l_re,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              r_we,
  input  logic              r_re,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] l_rdata_q,
  output logic [DATA_W-1:0] r_rdata_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              l_fwd, r_fwd;

  assign l_fwd = r_we && (r_addr == l_addr);
  assign r_fwd = l_we && (l_addr == r_addr);

  always_ff @(posedge clk) begin
    if (l_we) mem[l_addr] <= l_wdata;
    if (r_we) mem[r_addr] <= r_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata_q <= '0;
      r_rdata_q <= '0;
    end else begin
      if (l_re) l_rdata_q <= l_fwd ? r_wdata : mem[l_addr];
      if (r_re) r_rdata_q <= r_fwd ? l_wdata : mem[r_addr];
    end
  end

  // R7
  no_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_we && r_we && l_addr == r_addr));
  // R11
  left_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_re && r_we && l_addr == r_addr) |=> (l_rdata_q == $past(r_wdata)));
  // R11
  right_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_re && l_we && l_addr == r_addr) |=> (r_rdata_q == $past(l_wdata)));
endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              int_l_n,
  output logic              int_r_n
);
  localparam logic [ADDR_W-1:0] BOX_TO_R = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_TO_L = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic set_r, clr_r, set_l, clr_l;
  logic flag_r, flag_l;

  assign set_r = l_wr && (l_addr == BOX_TO_R);
  assign clr_r = r_rd && (r_addr == BOX_TO_R);
  assign set_l = r_wr && (r_addr == BOX_TO_L);
  assign clr_l = l_rd && (l_addr == BOX_TO_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_r <= 1'b0;
      flag_l <= 1'b0;
    end else begin
      if (set_r)      flag_r <= 1'b1;
      else if (clr_r) flag_r <= 1'b0;
      if (set_l)      flag_l <= 1'b1;
      else if (clr_l) flag_l <= 1'b0;
    end
  end

  assign int_r_n = ~flag_r;
  assign int_l_n = ~flag_l;

  // R8 R10
  set_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && l_addr == BOX_TO_R) |=> !int_r_n);
  // R8
  clr_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rd && r_addr == BOX_TO_R && !(l_wr && l_addr == BOX_TO_R)) |=> int_r_n);
  // R9 R10
  set_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_wr && r_addr == BOX_TO_L) |=> !int_l_n);
  // R9
  clr_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd && l_addr == BOX_TO_L && !(r_wr && r_addr == BOX_TO_L)) |=> int_l_n);
endmodule

// File: rtl/dpm_readout.sv
module dpm_readout #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] data_q,
  output logic              drive,
  output logic [DATA_W-1:0] dout
);
  logic act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= rd_req;
  end

  assign drive = act_q && !oe_n;
  assign dout  = drive ? data_q : '0;

  // R3
  drive_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> $past(rd_req));
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce_n,
  input  logic              l_rw,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_drive,
  output logic              l_busy_n,
  output logic              l_int_n,
  input  logic              r_ce_n,
  input  logic              r_rw,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_drive,
  output logic              r_busy_n,
  output logic              r_int_n
);
  logic l_sel, r_sel, busy_l, busy_r;
  logic l_we, r_we, l_re, r_re;
  logic [DATA_W-1:0] l_q, r_q;

  assign l_sel = !l_ce_n;
  assign r_sel = !r_ce_n;
  assign l_re  = l_sel && l_rw;
  assign r_re  = r_sel && r_rw;
  assign l_we  = l_sel && !l_rw && !busy_l;
  assign r_we  = r_sel && !r_rw && !busy_r;

  dpm_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_addr(l_addr),
    .r_sel(r_sel), .r_addr(r_addr),
    .busy_l(busy_l), .busy_r(busy_r)
  );

  dpm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .l_we(l_we), .l_re(l_re), .l_addr(l_addr), .l_wdata(l_wdata),
    .r_we(r_we), .r_re(r_re), .r_addr(r_addr), .r_wdata(r_wdata),
    .l_rdata_q(l_q), .r_rdata_q(r_q)
  );

  dpm_mailbox #(.ADDR_W(ADDR_W)) u_mbox (
    .clk(clk), .rst_n(rst_n),
    .l_wr(l_we), .l_rd(l_re), .l_addr(l_addr),
    .r_wr(r_we), .r_rd(r_re), .r_addr(r_addr),
    .int_l_n(l_int_n), .int_r_n(r_int_n)
  );

  dpm_readout #(.DATA_W(DATA_W)) u_lout (
    .clk(clk), .rst_n(rst_n), .rd_req(l_re), .oe_n(l_oe_n),
    .data_q(l_q), .drive(l_drive), .dout(l_rdata)
  );

  dpm_readout #(.DATA_W(DATA_W)) u_rout (
    .clk(clk), .rst_n(rst_n), .rd_req(r_re), .oe_n(r_oe_n),
    .data_q(r_q), .drive(r_drive), .dout(r_rdata)
  );

  assign l_busy_n = ~busy_l;
  assign r_busy_n = ~busy_r;

  // R2
  desel_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_ce_n |=> !l_drive);
  // R2
  desel_no_drive_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_ce_n |=> !r_drive);
endmodule

// File: tb/dpram_mailbox_test.sv
module dpram_mailbox_test;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int TOP_R = N - 1;
  localparam int TOP_L = N - 2;

  logic clk = 0, rst_n = 0;
  logic l_ce_n = 1, l_rw = 1, l_oe_n = 1, r_ce_n = 1, r_rw = 1, r_oe_n = 1;
  logic [AW-1:0] l_addr = 0, r_addr = 0;
  logic [DW-1:0] l_wdata = 0, r_wdata = 0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_drive, r_drive, l_busy_n, r_busy_n, l_int_n, r_int_n;

  dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW)) uut (.*);

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  string cur = "R12";

  // reference state
  int mem [N];
  bit p_lsel = 0, p_rsel = 0; int p_la = 0, p_ra = 0;
  int side = 0;               // 0 none, 1 left busy, 2 right busy
  bit fl = 0, fr = 0, lact = 0, ract = 0;
  int ld = 0, rd = 0;
  int los = 0;

  task automatic chk(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur, what, act, exp);
    end
  endtask

  task automatic tick();
    bit ls, rs, lnew, rnew, lwe, rwe;
    #1;
    ls = !l_ce_n; rs = !r_ce_n;
    lnew = (ls != p_lsel) || (int'(l_addr) != p_la);
    rnew = (rs != p_rsel) || (int'(r_addr) != p_ra);
    if (!(ls && rs && l_addr == r_addr)) los = 0;
    else if (rnew) los = 2;
    else if (lnew) los = 1;
    else los = side;
    chk("left busy", !l_busy_n, los == 1);
    chk("right busy", !r_busy_n, los == 2);
    @(posedge clk);
    lwe = ls && !l_rw && los != 1;
    rwe = rs && !r_rw && los != 2;
    if (ls && l_rw) ld = (rwe && r_addr == l_addr) ? int'(r_wdata) : mem[l_addr];
    if (rs && r_rw) rd = (lwe && l_addr == r_addr) ? int'(l_wdata) : mem[r_addr];
    lact = ls && l_rw; ract = rs && r_rw;
    if (lwe && l_addr == TOP_R) fr = 1;
    else if (rs && r_rw && r_addr == TOP_R) fr = 0;
    if (rwe && r_addr == TOP_L) fl = 1;
    else if (ls && l_rw && l_addr == TOP_L) fl = 0;
    if (lwe) mem[l_addr] = l_wdata;
    if (rwe) mem[r_addr] = r_wdata;
    p_lsel = ls; p_rsel = rs; p_la = l_addr; p_ra = r_addr; side = los;
    #1;
    chk("left int", !l_int_n, fl);
    chk("right int", !r_int_n, fr);
    chk("left drive", l_drive, lact && !l_oe_n);
    chk("right drive", r_drive, ract && !r_oe_n);
    chk("left data", l_rdata, l_drive ? ld : 0);
    chk("right data", r_rdata, r_drive ? rd : 0);
    @(negedge clk);
  endtask

  task automatic setl(bit ce_n, bit rw, bit oe_n, int a, int d);
    l_ce_n = ce_n; l_rw = rw; l_oe_n = oe_n; l_addr = a[AW-1:0]; l_wdata = d[DW-1:0];
  endtask
  task automatic setr(bit ce_n, bit rw, bit oe_n, int a, int d);
    r_ce_n = ce_n; r_rw = rw; r_oe_n = oe_n; r_addr = a[AW-1:0]; r_wdata = d[DW-1:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset busy", {l_busy_n, r_busy_n}, 3);
    chk("reset int", {l_int_n, r_int_n}, 3);
    chk("reset drive", {l_drive, r_drive}, 0);
    rst_n = 1;
    tick();

    // R1 fill through left, read back through right
    cur = "R1";
    for (int a = 0; a < N; a++) begin setl(0, 0, 1, a, a * 7 + 3); tick(); end
    setl(1, 1, 1, 0, 0);
    for (int a = 0; a < N; a++) begin setr(0, 1, 0, a, 0); tick(); end
    setr(0, 0, 1, 9, 8'h5a); tick();
    setr(1, 1, 0, 0, 0); setl(0, 1, 0, 9, 0); tick(); tick();

    // R2 deselected port does nothing
    cur = "R2";
    setl(1, 0, 0, 9, 8'hff); tick();
    setl(1, 0, 0, TOP_R, 8'h11); tick();
    setl(0, 1, 0, 9, 0); tick(); tick();

    // R3 output enable gates the drive
    cur = "R3";
    setl(0, 1, 1, 4, 0); tick();
    l_oe_n = 0; tick();
    setl(1, 1, 0, 4, 0); tick(); tick();

    // R4 right settled first, left arrives later and is blocked (R7)
    cur = "R4";
    setr(0, 1, 0, 20, 0); tick();
    setl(0, 0, 1, 20, 8'hee); tick();
    cur = "R7"; tick();
    setl(1, 1, 1, 0, 0); tick();
    setl(0, 1, 0, 20, 0); tick(); tick();
    setl(1, 1, 1, 0, 0); setr(1, 1, 1, 0, 0); tick();

    // R5 both arrive together: right loses, its write is dropped
    cur = "R5";
    setl(0, 1, 0, 30, 0); setr(0, 0, 1, 30, 8'h77); tick();
    cur = "R6"; tick(); tick();
    setr(1, 1, 1, 0, 0); tick();
    setl(0, 1, 0, 30, 0); tick();
    setl(1, 1, 1, 0, 0); tick();

    // R8 left to right mailbox
    cur = "R8";
    setl(0, 0, 1, TOP_R, 8'h42); tick(); setl(1, 1, 1, 0, 0); tick();
    setr(0, 1, 0, TOP_R, 0); tick(); setr(1, 1, 1, 0, 0); tick();

    // R9 right to left mailbox
    cur = "R9";
    setr(0, 0, 1, TOP_L, 8'h24); tick(); setr(1, 1, 1, 0, 0); tick();
    setl(0, 1, 0, TOP_L, 0); tick(); setl(1, 1, 1, 0, 0); tick();

    // R10 set and clear together; right writes first, left reads later (R11)
    cur = "R10";
    setr(0, 0, 1, TOP_L, 8'h31); tick();
    setl(0, 1, 0, TOP_L, 0); r_wdata = 8'h32; tick();
    cur = "R11"; tick();
    setl(1, 1, 1, 0, 0); setr(1, 1, 1, 0, 0); tick();
    cur = "R10";
    setl(0, 0, 1, TOP_R, 8'h55); setr(0, 1, 0, TOP_R, 0); tick();
    setl(1, 1, 1, 0, 0); setr(1, 1, 1, 0, 0); tick(); tick();

    // R11 write-first across different arrival orders
    cur = "R11";
    setl(0, 0, 1, 12, 8'h81); tick();
    setr(0, 1, 0, 12, 0); l_wdata = 8'h82; tick(); tick();
    setl(1, 1, 1, 0, 0); setr(1, 1, 1, 0, 0); tick();

    // R6 random contention over four addresses
    cur = "R6";
    for (int i = 0; i < 3000; i++) begin
      int pick [4] = '{0, 1, TOP_L, TOP_R};
      setl(($urandom % 4) == 0, $urandom % 2, $urandom % 2, pick[$urandom % 4], $urandom);
      setr(($urandom % 4) == 0, $urandom % 2, $urandom % 2, pick[$urandom % 4], $urandom);
      tick();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule